// File: doc/BRIEF.md
# Locked-Rate Square Wave Divider and XOR Phase Front End

This block is the input stage of a digital phase-locked loop. It is meant for a device that has no analog clock synthesizer. It receives two unrelated clocks: a reference clock, 10 MHz by default, and a local oscillator clock, 6.144 MHz by default. Each clock drives its own modulus counter. The moduli are chosen so that both domains reach the same terminal rate, 16 kHz, which is the largest rate that divides both inputs.

In each domain the terminal event is a registered pulse one clock cycle wide. That pulse is used only as the enable of a toggle flop. The toggle flop produces a square wave at half the terminal rate, 8 kHz, with exactly equal high and low times. No decoded or derived signal ever drives a clock pin. Every flop runs on its own domain's input clock.

The oscillator square wave crosses into the reference domain through a chain of synchronizer flops. A registered XOR of the two square waves then forms the phase error. The average duty of this error tracks the phase offset between the loops and feeds a loop filter outside this block.

Top module: `xpd_front`

## Requirements
- R1: In each domain the terminal pulse is high for exactly one cycle of that domain's clock and repeats every MOD cycles (REF_MOD for the reference, OSC_MOD for the oscillator).
- R2: After a domain's reset is released, its terminal pulse is first seen high after MOD-1 rising edges. Its square wave first reads 1 after MOD rising edges.
- R3: Each square wave changes level only on the edge that follows a terminal pulse. It is high for exactly MOD cycles and low for exactly MOD cycles, so its period is 2*MOD cycles (125 us at the default rates).
- R4: Each domain has a synchronous active-high reset that clears that domain's counter, terminal pulse and square wave to 0. The other domain keeps running unaffected.
- R5: phase_err is registered in the reference domain. On each reference edge it takes the XOR of ref_sq and the oscillator square wave after a two-flop synchronizer, so phase_err is ref_sq delayed one reference cycle when the oscillator is held in reset.
- R6: With both clocks locked, the fraction of reference cycles in which phase_err is 1 rises monotonically as the oscillator phase lag grows over one half period. It falls monotonically over the next half, from near 0 to near 1 and back.
- R7: While both resets are held, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 1 | Local oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| ref_tick | output | 1 | Reference terminal pulse, one ref_clk cycle wide |
| osc_tick | output | 1 | Oscillator terminal pulse, one osc_clk cycle wide |
| ref_sq | output | 1 | Reference square wave, 50% duty |
| osc_sq | output | 1 | Oscillator square wave, 50% duty, osc_clk domain |
| phase_err | output | 1 | Registered XOR phase error, ref_clk domain |

## Verification
The phase XOR register can see both square waves change level in the same reference cycle. This happens when the effective phase offset is close to zero, and it is where the error duty must reach its minimum without wrapping.

The bench sweeps the oscillator reset release over every oscillator cycle of one full square period, starting from a fixed reference alignment. It measures the error duty at each step and checks that the sequence rises for one half period and falls for the other, starting from its minimum. In each domain the terminal pulse and the toggle fall on adjacent edges, and the bench judges them by the exact high and low widths.

// File: rtl/xpd_pkg.sv
package xpd_pkg;
    // Default moduli: 10 MHz / 625 = 6.144 MHz / 384 = 16 kHz terminal rate
    localparam int unsigned REF_MOD_DEF = 625;
    localparam int unsigned OSC_MOD_DEF = 384;
    // Synchronizer depth for the oscillator square wave entering ref domain
    localparam int unsigned SYNC_DEPTH  = 2;
    // Domain indices used by the divider generate loop
    localparam int unsigned DOM_REF   = 0;
    localparam int unsigned DOM_OSC   = 1;
    localparam int unsigned NUM_DOMS  = 2;
endpackage

// File: rtl/xpd_mod_counter.sv
module xpd_mod_counter #(
    parameter int unsigned MOD = 625
) (
    input  logic clk,
    input  logic rst,
    output logic term_o
);
    localparam int unsigned    CW   = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [CW-1:0]  LAST = CW'(MOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          term;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // registered decode: glitch-free pulse while the count sits at LAST
        st_d.term = (st_d.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o = st_q.term;
endmodule

// File: rtl/xpd_toggle.sv
module xpd_toggle (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic sq_o
);
    typedef struct packed {
        logic sq;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sq = st_q.sq ^ en_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_o = st_q.sq;
endmodule

// File: rtl/xpd_sync.sv
module xpd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/xpd_phase_xor.sv
module xpd_phase_xor (
    input  logic clk,
    input  logic rst,
    input  logic a_i,
    input  logic b_i,
    output logic err_o
);
    typedef struct packed {
        logic err;
    } xor_state_t;

    xor_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = a_i ^ b_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/xpd_front.sv
module xpd_front
    import xpd_pkg::*;
#(
    parameter int unsigned REF_MOD = REF_MOD_DEF,
    parameter int unsigned OSC_MOD = OSC_MOD_DEF
) (
    input  logic ref_clk,
    input  logic ref_rst,
    input  logic osc_clk,
    input  logic osc_rst,
    output logic ref_tick,
    output logic osc_tick,
    output logic ref_sq,
    output logic osc_sq,
    output logic phase_err
);
    logic [NUM_DOMS-1:0] dom_clk;
    logic [NUM_DOMS-1:0] dom_rst;
    logic [NUM_DOMS-1:0] dom_tick;
    logic [NUM_DOMS-1:0] dom_sq;
    logic                osc_in_ref;

    assign dom_clk[DOM_REF] = ref_clk;
    assign dom_clk[DOM_OSC] = osc_clk;
    assign dom_rst[DOM_REF] = ref_rst;
    assign dom_rst[DOM_OSC] = osc_rst;

    // One divider chain per clock domain; each chain sees only its own clock.
    for (genvar g = 0; g < NUM_DOMS; g++) begin : g_dom
        localparam int unsigned DMOD = (g == DOM_REF) ? REF_MOD : OSC_MOD;

        xpd_mod_counter #(.MOD(DMOD)) u_cnt (
            .clk    (dom_clk[g]),
            .rst    (dom_rst[g]),
            .term_o (dom_tick[g])
        );

        xpd_toggle u_tog (
            .clk  (dom_clk[g]),
            .rst  (dom_rst[g]),
            .en_i (dom_tick[g]),
            .sq_o (dom_sq[g])
        );
    end

    xpd_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (ref_clk),
        .rst (ref_rst),
        .d_i (dom_sq[DOM_OSC]),
        .q_o (osc_in_ref)
    );

    xpd_phase_xor u_pd (
        .clk   (ref_clk),
        .rst   (ref_rst),
        .a_i   (dom_sq[DOM_REF]),
        .b_i   (osc_in_ref),
        .err_o (phase_err)
    );

    assign ref_tick = dom_tick[DOM_REF];
    assign osc_tick = dom_tick[DOM_OSC];
    assign ref_sq   = dom_sq[DOM_REF];
    assign osc_sq   = dom_sq[DOM_OSC];
endmodule

// File: rtl/xpd_front_chk.sv
module xpd_front_chk (
    input logic ref_clk,
    input logic ref_rst,
    input logic osc_clk,
    input logic osc_rst,
    input logic ref_tick,
    input logic osc_tick,
    input logic ref_sq,
    input logic osc_sq,
    input logic osc_in_ref,
    input logic phase_err
);
    // R1: terminal pulses are a single cycle wide
    p_tick_narrow_ref_r1: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ref_tick |=> !ref_tick);
    p_tick_narrow_osc_r1: assert property (@(posedge osc_clk) disable iff (osc_rst)
        osc_tick |=> !osc_tick);

    // R3: square waves hold unless enabled, and flip when enabled
    p_sq_hold_ref_r3: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !ref_tick |=> $stable(ref_sq));
    p_sq_flip_ref_r3: assert property (@(posedge ref_clk) disable iff (ref_rst)
        ref_tick |=> (ref_sq != $past(ref_sq)));
    p_sq_hold_osc_r3: assert property (@(posedge osc_clk) disable iff (osc_rst)
        !osc_tick |=> $stable(osc_sq));
    p_sq_flip_osc_r3: assert property (@(posedge osc_clk) disable iff (osc_rst)
        osc_tick |=> (osc_sq != $past(osc_sq)));

    // R4: each domain reset clears its pulse and square wave
    p_reset_clr_ref_r4: assert property (@(posedge ref_clk)
        ref_rst |=> (!ref_sq && !ref_tick));
    p_reset_clr_osc_r4: assert property (@(posedge osc_clk)
        osc_rst |=> (!osc_sq && !osc_tick));

    // R5: phase error is last cycle's XOR of the ref wave and synchronized osc wave
    p_err_xor_r5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !$past(ref_rst) |-> (phase_err == ($past(ref_sq) ^ $past(osc_in_ref))));
endmodule

bind xpd_front xpd_front_chk u_chk (
    .ref_clk    (ref_clk),
    .ref_rst    (ref_rst),
    .osc_clk    (osc_clk),
    .osc_rst    (osc_rst),
    .ref_tick   (ref_tick),
    .osc_tick   (osc_tick),
    .ref_sq     (ref_sq),
    .osc_sq     (osc_sq),
    .osc_in_ref (osc_in_ref),
    .phase_err  (phase_err)
);

// File: tb/tb_xpd_front.sv
`timescale 1ns/1ps
module tb_xpd_front;
    localparam int unsigned RM     = 5;   // 125 MHz / 5 = 25 MHz terminal rate
    localparam int unsigned OM     = 4;   // 100 MHz / 4 = 25 MHz terminal rate
    localparam int unsigned MEAS   = 200; // ref cycles per duty measurement
    localparam int unsigned NOFF   = 2 * OM;

    logic ref_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic ref_rst = 1'b1;
    logic osc_rst = 1'b1;
    logic ref_tick, osc_tick, ref_sq, osc_sq, phase_err;

    int tests = 0;
    int fails = 0;

    xpd_front #(.REF_MOD(RM), .OSC_MOD(OM)) dut (
        .ref_clk   (ref_clk),
        .ref_rst   (ref_rst),
        .osc_clk   (osc_clk),
        .osc_rst   (osc_rst),
        .ref_tick  (ref_tick),
        .osc_tick  (osc_tick),
        .ref_sq    (ref_sq),
        .osc_sq    (osc_sq),
        .phase_err (phase_err)
    );

    initial forever #4 ref_clk = ~ref_clk;           // 125 MHz
    initial begin #1.5; forever #5 osc_clk = ~osc_clk; end  // 100 MHz, offset edges

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit use_osc);
        if (use_osc) @(negedge osc_clk);
        else         @(negedge ref_clk);
    endtask

    // Measure one full high run and one full low run of a square wave
    task automatic measure_sq(input bit use_osc, output int hi, output int lo);
        bit v;
        hi = 0; lo = 0;
        do begin step(use_osc); v = use_osc ? osc_sq : ref_sq; end while (v != 1'b0);
        do begin step(use_osc); v = use_osc ? osc_sq : ref_sq; end while (v != 1'b1);
        while (v == 1'b1) begin hi++; step(use_osc); v = use_osc ? osc_sq : ref_sq; end
        while (v == 1'b0) begin lo++; step(use_osc); v = use_osc ? osc_sq : ref_sq; end
    endtask

    // Check pulse width and spacing over several periods
    task automatic check_ticks(input bit use_osc, input int unsigned md, input string req);
        int last = -1;
        int bad_gap = 0;
        int bad_wid = 0;
        bit prev = 1'b0;
        bit t;
        for (int i = 0; i < int'(6 * md); i++) begin
            step(use_osc);
            t = use_osc ? osc_tick : ref_tick;
            if (t && prev) bad_wid++;
            if (t) begin
                if (last >= 0 && (i - last) != int'(md)) bad_gap++;
                last = i;
            end
            prev = t;
        end
        chk(bad_wid == 0, {req, " pulse width"}, bad_wid, 0);
        chk(bad_gap == 0, {req, " pulse spacing"}, bad_gap, 0);
    endtask

    task automatic release_ref_aligned();
        longint t;
        do begin @(negedge ref_clk); t = longint'($time); end while ((t % 40) != 0);
        ref_rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi, lo, first_tick, mism;
        bit prev_sq;
        int duty [NOFF];
        int mn_i, mx_v, mn_v, bad_mono;

        repeat (3) @(negedge ref_clk);
        // R7: everything zero while both resets are held
        chk({ref_tick, osc_tick, ref_sq, osc_sq, phase_err} == 5'b0, "R7 reset outputs",
            int'({ref_tick, osc_tick, ref_sq, osc_sq, phase_err}), 0);

        // R2: first pulse and first rise after reset release
        release_ref_aligned();
        first_tick = -1;
        for (int k = 1; k <= int'(RM); k++) begin
            @(negedge ref_clk);
            if (ref_tick && first_tick < 0) first_tick = k;
            if (k == int'(RM) - 1) chk(ref_sq == 1'b0, "R2 sq low before first toggle", int'(ref_sq), 0);
            if (k == int'(RM))     chk(ref_sq == 1'b1, "R2 sq high after MOD edges", int'(ref_sq), 1);
        end
        chk(first_tick == int'(RM) - 1, "R2 first pulse edge", first_tick, int'(RM) - 1);

        // R1, R3 reference domain
        check_ticks(1'b0, RM, "R1 ref");
        measure_sq(1'b0, hi, lo);
        chk(hi == int'(RM), "R3 ref high time", hi, int'(RM));
        chk(lo == int'(RM), "R3 ref low time", lo, int'(RM));
        chk(hi + lo == int'(2 * RM), "R3 ref period", hi + lo, int'(2 * RM));

        // R4: oscillator domain still cleared while reference runs
        chk({osc_sq, osc_tick} == 2'b0, "R4 osc held in reset", int'({osc_sq, osc_tick}), 0);

        // R5: with osc in reset, phase_err is ref_sq delayed one cycle
        mism = 0;
        @(negedge ref_clk); prev_sq = ref_sq;
        for (int i = 0; i < 40; i++) begin
            @(negedge ref_clk);
            if (phase_err != prev_sq) mism++;
            prev_sq = ref_sq;
        end
        chk(mism == 0, "R5 err equals delayed ref_sq", mism, 0);

        // R1, R3 oscillator domain
        @(negedge osc_clk); osc_rst = 1'b0;
        check_ticks(1'b1, OM, "R1 osc");
        measure_sq(1'b1, hi, lo);
        chk(hi == int'(OM), "R3 osc high time", hi, int'(OM));
        chk(lo == int'(OM), "R3 osc low time", lo, int'(OM));

        // R4: reset reference mid-run, oscillator keeps its 50% wave
        @(negedge ref_clk); ref_rst = 1'b1;
        @(negedge ref_clk); @(negedge ref_clk);
        chk({ref_sq, ref_tick} == 2'b0, "R4 ref cleared by reset", int'({ref_sq, ref_tick}), 0);
        measure_sq(1'b1, hi, lo);
        chk(hi == int'(OM) && lo == int'(OM), "R4 osc unaffected by ref reset", hi + lo, int'(2 * OM));
        chk({ref_sq, ref_tick} == 2'b0, "R4 ref stays cleared", int'({ref_sq, ref_tick}), 0);

        // R6: sweep osc phase over one full square period
        for (int d = 0; d < int'(NOFF); d++) begin
            ref_rst = 1'b1; osc_rst = 1'b1;
            repeat (3) @(negedge ref_clk);
            release_ref_aligned();
            repeat (d + 1) @(negedge osc_clk);
            osc_rst = 1'b0;
            repeat (60) @(negedge ref_clk);
            duty[d] = 0;
            for (int i = 0; i < int'(MEAS); i++) begin
                @(negedge ref_clk);
                if (phase_err) duty[d]++;
            end
        end
        mn_i = 0; mn_v = duty[0]; mx_v = duty[0];
        for (int d = 1; d < int'(NOFF); d++) begin
            if (duty[d] < mn_v) begin mn_v = duty[d]; mn_i = d; end
            if (duty[d] > mx_v) mx_v = duty[d];
        end
        bad_mono = 0;
        for (int i = 0; i < int'(NOFF); i++) begin
            int a = duty[(mn_i + i) % int'(NOFF)];
            int b = duty[(mn_i + i + 1) % int'(NOFF)];
            if (i < int'(OM) && b < a) bad_mono++;
            if (i >= int'(OM) && b > a) bad_mono++;
        end
        chk(bad_mono == 0, "R6 duty monotonic per half period", bad_mono, 0);
        chk(mn_v * 10 <= int'(MEAS) * 3, "R6 minimum duty near zero", mn_v, 0);
        chk(mx_v * 10 >= int'(MEAS) * 7, "R6 maximum duty near one", mx_v, int'(MEAS));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule